// File: doc/BRIEF.md
# Bridge Protection Fault Sequencer

This block is the protection state machine for a motor driver with several H-bridges. Each bridge supplies a raw flag that goes high while its switches are being current-limited. All bridges share one over-temperature flag. For each bridge the block filters the current-limit flag, shuts the bridge down when the condition persists, and re-enables it after a fixed retry period. It does this again and again for as long as the condition stays. A bridge in overcurrent never affects the other bridges.

While over-temperature is present, every bridge is held off, and each resumes by itself once the flag clears. Any bridge that is off pulls the shared active-low fault output low, in the manner of a wired-AND open-drain pin. Both time windows are set in nanoseconds and converted to clock cycles from a clock-frequency parameter. With the default settings the filter lasts 4 µs and the retry period lasts 1.35 ms.

Top module: `prot_seq`

## Requirements
- R1: After reset, every `bridge_off` bit is 0 and `fault_n` is 1.
- R2: A high level on `oc_flag[i]` seen at fewer than DEG consecutive rising clock edges has no effect. `bridge_off[i]` stays 0 and `fault_n` stays 1.
- R3: When `oc_flag[i]` is seen high at DEG consecutive rising edges while over-temperature is low, `bridge_off[i]` is 1 from the DEG-th edge onward. With default parameters DEG is 200 cycles, which is 4 µs at 50 MHz.
- R4: After an overcurrent shutdown, `bridge_off[i]` stays 1 for exactly RET edges and returns to 0 on the RET-th edge. With default parameters RET is 67500 cycles, which is 1.35 ms at 50 MHz. `fault_n` rises on that same edge if nothing else holds it low.
- R5: If `oc_flag[i]` is still high at re-enable, a new filter window of DEG edges starts from that edge. A new shutdown and retry cycle then follows.
- R6: An overcurrent on bridge i never sets `bridge_off[j]` for any j ≠ i.
- R7: While `ot_flag` is 1, every `bridge_off` bit is 1 and `fault_n` is 0, with no clock edge needed. A bridge with no pending overcurrent shutdown is enabled as soon as `ot_flag` returns to 0.
- R8: If `ot_flag` is 1 when a retry period ends, the bridge remains off until `ot_flag` clears.
- R9: Edges at which `ot_flag` is 1 restart the overcurrent filter. The DEG consecutive edges must all have `ot_flag` at 0.
- R10: `fault_n` is 0 exactly when at least one `bridge_off` bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that sets the timer resolution |
| rst_n | input | 1 | Asynchronous active-low reset |
| oc_flag | input | NB | Raw current-limit flag, one bit per bridge |
| ot_flag | input | 1 | Shared over-temperature flag |
| bridge_off | output | NB | High forces every switch of that bridge off |
| fault_n | output | 1 | Combined active-low fault request |

## Verification
The bench sweeps the length of the overcurrent pulse from one edge up to the filter length. This separates pulses that are ignored from a confirmed trip, and it pins the trip to the exact edge. A fault held across re-enable shows that the retry period is exact and that the filter restarts. Over-temperature is applied in three places: alone, in the middle of the filter, and across the end of a retry. These cases tell the immediate thermal disable apart from the filter restart and the extended hold. Trips on one bridge while watching the other confirm that the bridges stay isolated.

// File: rtl/prot_seq.sv
module prot_seq #(
  parameter int NB       = 2,
  parameter int CLK_KHZ  = 50000,
  parameter int DEG_NS   = 4000,
  parameter int RETRY_NS = 1350000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] oc_flag,
  input  logic          ot_flag,
  output logic [NB-1:0] bridge_off,
  output logic          fault_n
);
  localparam longint DEG_L  = (longint'(CLK_KHZ) * DEG_NS + 999999) / 1000000;
  localparam longint RET_L  = (longint'(CLK_KHZ) * RETRY_NS + 999999) / 1000000;
  localparam int     DEG_CYC = (DEG_L < 1) ? 1 : int'(DEG_L);
  localparam int     RET_CYC = (RET_L < 2) ? 2 : int'(RET_L);
  localparam int     TOP     = (DEG_CYC > RET_CYC) ? DEG_CYC : RET_CYC;
  localparam int     CW      = $clog2(TOP + 1);
  localparam logic [CW-1:0] DEG_END = CW'(DEG_CYC - 1);
  localparam logic [CW-1:0] RET_END = CW'(RET_CYC - 1);

  for (genvar g = 0; g < NB; g++) begin : g_br
    logic          tripped;
    logic [CW-1:0] cnt;

    // R2 R3 R9: filter; R4 R5: retry timer
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tripped <= 1'b0;
        cnt     <= '0;
      end else if (!tripped) begin
        if (!oc_flag[g] || ot_flag) cnt <= '0;
        else if (cnt == DEG_END) begin
          tripped <= 1'b1;
          cnt     <= '0;
        end else cnt <= cnt + 1'b1;
      end else if (cnt == RET_END) begin
        tripped <= 1'b0;
        cnt     <= '0;
      end else cnt <= cnt + 1'b1;
    end

    // R7 R8: thermal hold overrides
    assign bridge_off[g] = tripped | ot_flag;
  end

  // R10: wired-AND of fault requests
  assign fault_n = ~|bridge_off;
endmodule

module prot_seq_chk #(parameter int NB = 2) (
  input logic          clk,
  input logic          rst_n,
  input logic [NB-1:0] oc_flag,
  input logic          ot_flag,
  input logic [NB-1:0] bridge_off,
  input logic          fault_n
);
  AST_FAULT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (|bridge_off) |-> !fault_n); // R10
  AST_THERMAL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ot_flag |-> (&bridge_off)); // R7

  for (genvar g = 0; g < NB; g++) begin : g_chk
    AST_TRIP_NEEDS_OC: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(bridge_off[g]) && !ot_flag) |-> $past(oc_flag[g])); // R3
    AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(bridge_off[g]) && !ot_flag) |=> bridge_off[g]); // R4
    AST_NO_REENABLE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bridge_off[g]) |-> !ot_flag); // R8
  end
endmodule

bind prot_seq prot_seq_chk #(.NB(NB)) chk_i (
  .clk(clk), .rst_n(rst_n), .oc_flag(oc_flag), .ot_flag(ot_flag),
  .bridge_off(bridge_off), .fault_n(fault_n)
);

// File: tb/prot_seq_tb_top.sv
module prot_seq_tb_top;
  localparam int NB = 2;
  localparam int D  = 4;
  localparam int R  = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NB-1:0] oc_flag = '0;
  logic ot_flag = 1'b0;
  logic [NB-1:0] bridge_off;
  logic fault_n;
  int errs = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  prot_seq #(.NB(NB), .CLK_KHZ(1000), .DEG_NS(4000), .RETRY_NS(20000)) dut_i (
    .clk(clk), .rst_n(rst_n), .oc_flag(oc_flag), .ot_flag(ot_flag),
    .bridge_off(bridge_off), .fault_n(fault_n));

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(string req, logic [NB-1:0] exp_off);
    logic exp_f;
    exp_f = ~|exp_off;
    checks++;
    if (bridge_off !== exp_off || fault_n !== exp_f) begin
      errs++;
      $display("FAIL %s: off=%b fault_n=%b expected off=%b fault_n=%b",
               req, bridge_off, fault_n, exp_off, exp_f);
    end
  endtask

  initial begin
    #4000000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: run hung");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    step(); step();
    chk("R1", 2'b00);
    rst_n = 1'b1;
    step();
    chk("R1", 2'b00);

    // R2: pulse sweep below filter length
    for (int b = 0; b < NB; b++) begin
      for (int len = 1; len < D; len++) begin
        oc_flag[b] = 1'b1;
        for (int k = 0; k < len; k++) begin step(); chk("R2", 2'b00); end
        oc_flag[b] = 1'b0;
        step(); chk("R2", 2'b00);
      end
    end

    // R3 R4 R6 R10: single trip per bridge
    for (int b = 0; b < NB; b++) begin
      logic [NB-1:0] m;
      m = '0; m[b] = 1'b1;
      oc_flag[b] = 1'b1;
      for (int k = 0; k < D - 1; k++) begin step(); chk("R3", 2'b00); end
      step(); chk("R3 R6 R10", m);
      oc_flag[b] = 1'b0;
      for (int k = 0; k < R - 1; k++) begin step(); chk("R4", m); end
      step(); chk("R4", 2'b00);
    end

    // R5: persistent fault repeats
    oc_flag[0] = 1'b1;
    for (int cyc = 0; cyc < 2; cyc++) begin
      for (int k = 0; k < D - 1; k++) begin step(); chk("R5", 2'b00); end
      step(); chk("R5", 2'b01);
      for (int k = 0; k < R - 1; k++) begin step(); chk("R5", 2'b01); end
      step(); chk("R5", 2'b00);
    end
    oc_flag[0] = 1'b0;
    step(); chk("R5", 2'b00);

    // R7: thermal immediate, then release
    #3 ot_flag = 1'b1;
    #1 chk("R7", 2'b11);
    step(); step(); chk("R7", 2'b11);
    ot_flag = 1'b0;
    #1 chk("R7", 2'b00);

    // R9: thermal edge restarts filter
    oc_flag[1] = 1'b1;
    for (int k = 0; k < D - 1; k++) begin step(); chk("R9", 2'b00); end
    ot_flag = 1'b1;
    step();
    ot_flag = 1'b0;
    #1 chk("R9", 2'b00);
    for (int k = 0; k < D - 1; k++) begin step(); chk("R9", 2'b00); end
    step(); chk("R9", 2'b10);
    oc_flag[1] = 1'b0;
    for (int k = 0; k < R; k++) step();
    chk("R9", 2'b00);

    // R8: thermal spans retry end
    oc_flag[0] = 1'b1;
    for (int k = 0; k < D; k++) step();
    chk("R8", 2'b01);
    oc_flag[0] = 1'b0;
    ot_flag = 1'b1;
    for (int k = 0; k < R + 3; k++) step();
    chk("R8", 2'b11);
    ot_flag = 1'b0;
    #1 chk("R8", 2'b00);
    step(); chk("R8", 2'b00);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule